// File: doc/BRIEF.md
# Quad Programmable Down-Counter Timer

The block is a memory-mapped timer peripheral. It holds four independent down-counters that share one interrupt unit. Each channel has a live count, a load word, a background reload word and an 8-bit control byte. Software writes the load word to restart the channel at a chosen value. The control byte sets the enable, the counting mode (free-running, periodic or one-shot), a prescaler of 1, 16 or 256, and a counter width of 16 or 32 bits.

Every channel owns one raw interrupt bit, with bit n belonging to channel n. A periodic or free-running channel raises its bit each time it underflows. A one-shot channel raises its bit when it reaches zero. A mask word selects which raw bits drive the single interrupt line. Software clears raw bits by writing ones to the clear word.

The register port is synchronous and APB-like. A write takes effect on the clock edge where `psel`, `penable` and `pwrite` are all high. Read data is combinational from the address. Word offsets are 0x00 for the mask, 0x04 for raw status, 0x08 for masked status and 0x0C for clear. Channel n occupies 0x10 + 0x10·n, with the load word at +0x0, the count at +0x4, control at +0x8 and the background reload at +0xC.

Top module: `quad_down_timer`

## Requirements
- R1: After reset, the mask, raw status and every control byte read 0, and every load and background word reads 0xFFFFFFFF. Every count holds all ones; because the reset control selects 16-bit width, it reads 0x0000FFFF.
- R2: The control byte keeps bits 7, 6 and 3:0, and bits 5:4 read as zero. Load and background words read back as written. The clear word reads 0. Raw status changes only on a channel event or a clear write.
- R3: A write to a channel's load word copies the value into the counter on the same edge and restarts that channel's prescaler phase.
- R4: Control bits 3:2 set the decrement rate. 00 gives one step per clock, 01 one step per 16 clocks, and 10 or 11 one step per 256 clocks, counted from the load write.
- R5: With control bit 1 clear, only the low 16 bits count, and the count word reads with bits 31:16 as zero. With bit 1 set, the full 32 bits count.
- R6: Free-running mode (bit 6 = 0, bit 0 = 0): a step from zero wraps the count to the all-ones value of the selected width and sets the channel's raw bit.
- R7: Periodic mode (bit 6 = 1, bit 0 = 0): a step from zero reloads the count from the background word, truncated to the width, and sets the raw bit. A write to the background word does not change the current count.
- R8: One-shot mode (bit 0 = 1): a step from 1 to 0 sets the raw bit. The count then stays at zero, and raises no further interrupt, until it is reloaded.
- R9: With control bit 7 clear, the count holds its value. Only a load write changes it.
- R10: Masked status reads raw AND mask, and the `irq` output is high exactly when masked status is non-zero.
- R11: Writing the clear word clears each raw bit whose written bit is 1 and leaves the other raw bits unchanged. A channel event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq | output | 1 | OR of the masked status bits |

## Verification
The bench targets the edges of the count sequence. It checks the exact step on which each prescaler moves the count. A prescaler that is not restarted by the load write, or that counts one phase too many, shows a wrong value in a 16- or 256-cycle window. It also checks that a periodic channel reloads from the background word only at underflow and not at the moment that word is written. A design that copied the word early would show the new value right away. It checks that a free-running 16-bit channel wraps to 0xFFFF and not to a 32-bit all-ones value. Finally, it checks that a one-shot channel stays silent after its interrupt is cleared, and that a partial clear write leaves the other raw bits standing.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int CNT_W    = 32;
  localparam int NARROW_W = 16;
  localparam int PRE_W    = 8;

  typedef enum logic [1:0] {
    PRE_DIV1    = 2'b00,
    PRE_DIV16   = 2'b01,
    PRE_DIV256  = 2'b10,
    PRE_DIV256B = 2'b11
  } pre_sel_e;

  typedef struct packed {
    logic     en;
    logic     periodic;
    logic [1:0] rsv;
    pre_sel_e pre;
    logic     wide;
    logic     oneshot;
  } ctl_t;

  // last prescaler phase before a step
  function automatic logic [PRE_W-1:0] pre_last(pre_sel_e s);
    case (s)
      PRE_DIV1:  return '0;
      PRE_DIV16: return PRE_W'(15);
      default:   return '1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] width_mask(logic wide);
    return wide ? {CNT_W{1'b1}} : CNT_W'({NARROW_W{1'b1}});
  endfunction

  // value after one step
  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] cur, ctl_t c,
                                                  logic [CNT_W-1:0] bg);
    logic [CNT_W-1:0] m;
    logic [CNT_W-1:0] v;
    m = width_mask(c.wide);
    v = cur & m;
    if (v != '0)    return (v - CNT_W'(1)) & m;
    if (c.oneshot)  return '0;
    if (c.periodic) return bg & m;
    return m;
  endfunction

  // does this step raise the channel interrupt
  function automatic logic step_fires(logic [CNT_W-1:0] cur, ctl_t c);
    logic [CNT_W-1:0] v;
    v = cur & width_mask(c.wide);
    return c.oneshot ? (v == CNT_W'(1)) : (v == '0);
  endfunction
endpackage

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic             bg_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] bg_o,
  output logic [CNT_W-1:0] cnt_o,
  output ctl_t             ctl_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] load_q, bg_q, cnt_q;
  logic [PRE_W-1:0] pre_q;
  ctl_t             ctl_q;
  logic             tick;

  assign tick  = ctl_q.en && (pre_q == pre_last(ctl_q.pre));
  assign evt_o = tick && !ld_we && step_fires(cnt_q, ctl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '1;
      bg_q   <= '1;
      cnt_q  <= '1;
      ctl_q  <= '0;
      pre_q  <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q     <= ctl_t'(wdata[7:0]);
        ctl_q.rsv <= 2'b00;
      end
      if (bg_we) bg_q <= wdata;
      if (ld_we) begin
        load_q <= wdata;
        cnt_q  <= wdata;
      end else if (tick) begin
        cnt_q <= step_count(cnt_q, ctl_q, bg_q);
      end
      if (ld_we || tick || !ctl_q.en) pre_q <= '0;
      else                             pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign load_o = load_q;
  assign bg_o   = bg_q;
  assign cnt_o  = cnt_q & width_mask(ctl_q.wide);
  assign ctl_o  = ctl_q;
endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           mask_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] ris_o,
  output logic [NCH-1:0] mis_o,
  output logic           irq_o
);
  logic [NCH-1:0] mask_q, ris_q, clr_vec;

  assign clr_vec = clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ris_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wbits;
      ris_q <= (ris_q & ~clr_vec) | evt;
    end
  end

  assign mask_o = mask_q;
  assign ris_o  = ris_q;
  assign mis_o  = ris_q & mask_q;
  assign irq_o  = |mis_o;
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
  import qdt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [CNT_W-1:0] pwdata,
  output logic [CNT_W-1:0] prdata,
  output logic             irq
);
  localparam int GRP_W = AW - 4;

  logic             wr, word_ok;
  logic [GRP_W-1:0] grp;
  logic [1:0]       off;

  // named internal events for the checker
  logic [NCH-1:0]            ld_we, bg_we, ctl_we, ch_evt, ch_en, ch_os;
  logic [NCH-1:0][CNT_W-1:0] ch_load, ch_bg, ch_cnt;
  ctl_t [NCH-1:0]            ch_ctl;
  logic                      mask_we, clr_stb;
  logic [NCH-1:0]            clr_bits, mask, ris, mis;

  assign word_ok  = (paddr[1:0] == 2'b00);
  assign grp      = paddr[AW-1:4];
  assign off      = paddr[3:2];
  assign wr       = psel && penable && pwrite && word_ok;
  assign mask_we  = wr && (grp == '0) && (off == 2'd0);
  assign clr_stb  = wr && (grp == '0) && (off == 2'd3);
  assign clr_bits = pwdata[NCH-1:0];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel       = wr && (grp == GRP_W'(n + 1));
    assign ld_we[n]  = sel && (off == 2'd0);
    assign ctl_we[n] = sel && (off == 2'd2);
    assign bg_we[n]  = sel && (off == 2'd3);
    assign ch_en[n]  = ch_ctl[n].en;
    assign ch_os[n]  = ch_ctl[n].oneshot;

    qdt_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_we  (ld_we[n]),
      .bg_we  (bg_we[n]),
      .ctl_we (ctl_we[n]),
      .wdata  (pwdata),
      .load_o (ch_load[n]),
      .bg_o   (ch_bg[n]),
      .cnt_o  (ch_cnt[n]),
      .ctl_o  (ch_ctl[n]),
      .evt_o  (ch_evt[n])
    );
  end

  qdt_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (ch_evt),
    .mask_we (mask_we),
    .clr_we  (clr_stb),
    .wbits   (clr_bits),
    .mask_o  (mask),
    .ris_o   (ris),
    .mis_o   (mis),
    .irq_o   (irq)
  );

  always_comb begin
    prdata = '0;
    if (word_ok) begin
      if (grp == '0) begin
        case (off)
          2'd0:    prdata = CNT_W'(mask);
          2'd1:    prdata = CNT_W'(ris);
          2'd2:    prdata = CNT_W'(mis);
          default: prdata = '0;
        endcase
      end
      for (int n = 0; n < NCH; n++) begin
        if (grp == GRP_W'(n + 1)) begin
          case (off)
            2'd0:    prdata = ch_load[n];
            2'd1:    prdata = ch_cnt[n];
            2'd2:    prdata = CNT_W'(ch_ctl[n]);
            default: prdata = ch_bg[n];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker
  import qdt_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            ch_evt,
  input logic [NCH-1:0]            ch_en,
  input logic [NCH-1:0]            ch_os,
  input logic [NCH-1:0]            ld_we,
  input logic [NCH-1:0]            ctl_we,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0]            ris,
  input logic [NCH-1:0]            mask,
  input logic                      clr_stb,
  input logic [NCH-1:0]            clr_bits,
  input logic                      irq
);
  a_r11_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_evt != '0) |=> ((ris & $past(ch_evt)) == $past(ch_evt)));

  a_r11_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((ris & $past(clr_bits & ~ch_evt)) == '0));

  a_r2_raw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_stb && ch_evt == '0) |=> $stable(ris));

  a_r10_irq_needs_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((ris & mask) == '0) |-> !irq);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[i] && !ld_we[i] && !ctl_we[i]) |=> $stable(ch_cnt[i]));

    a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_os[i] && ch_cnt[i] == '0 && !ld_we[i] && !ctl_we[i])
        |=> (ch_cnt[i] == '0 && !ch_evt[i]));
  end
endmodule

bind quad_down_timer qdt_checker #(.NCH(NCH)) u_qdt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_evt   (ch_evt),
  .ch_en    (ch_en),
  .ch_os    (ch_os),
  .ld_we    (ld_we),
  .ctl_we   (ctl_we),
  .ch_cnt   (ch_cnt),
  .ris      (ris),
  .mask     (mask),
  .clr_stb  (clr_stb),
  .clr_bits (clr_bits),
  .irq      (irq)
);

// File: tb/quad_down_timer_tb.sv
module quad_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] cmp_mask;
    string       tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  event     rd_ev;

  always #4 clk = ~clk;

  quad_down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  localparam logic [7:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MSK = 8'h08, A_CLR = 8'h0C;

  function automatic logic [7:0] ch_a(int ch, int word);
    return 8'(16 + 16 * ch + 4 * word);
  endfunction

  // monitor: pops expected items as reads complete
  initial begin
    forever begin
      @(rd_ev);
      if (sb_q.size() != 0) begin
        rd_item_t it;
        it = sb_q.pop_front();
        checks++;
        if ((prdata & it.cmp_mask) !== (it.exp & it.cmp_mask)) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h (mask %h)", it.tag, prdata, it.exp, it.cmp_mask);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd_m(input logic [7:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    rd_item_t it;
    it.exp = e; it.cmp_mask = m; it.tag = tag;
    sb_q.push_back(it);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 -> rd_ev;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_m(a, e, 32'hFFFF_FFFF, tag);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, irq, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_RAW, 32'h0, "R1 raw");
    rd(ch_a(0, 0), 32'hFFFF_FFFF, "R1 load0");
    rd(ch_a(0, 1), 32'h0000_FFFF, "R1 R5 count0 16-bit view");
    rd(ch_a(3, 3), 32'hFFFF_FFFF, "R1 bg3");
    rd(ch_a(2, 2), 32'h0, "R1 ctl2");
    chk_irq(1'b0, "R1 irq");

    // R2 register map behaviour
    wr(ch_a(1, 2), 32'h0000_003F);
    rd(ch_a(1, 2), 32'h0000_000F, "R2 ctl reserved bits");
    wr(ch_a(1, 3), 32'hA5A5_0001);
    rd(ch_a(1, 3), 32'hA5A5_0001, "R2 bg readback");
    wr(ch_a(1, 2), 32'h0);
    rd(A_CLR, 32'h0, "R2 clear reads zero");

    // R3 load copies into counter, R9 disabled holds
    wr(ch_a(0, 2), 32'h02);
    wr(ch_a(0, 0), 32'h1234_5678);
    rd(ch_a(0, 1), 32'h1234_5678, "R3 load to count");
    idle(20);
    rd(ch_a(0, 1), 32'h1234_5678, "R9 disabled holds");
    // R5 16-bit view
    wr(ch_a(0, 2), 32'h00);
    rd(ch_a(0, 1), 32'h0000_5678, "R5 upper bits zero");

    // R8 one-shot, divide by 1
    wr(ch_a(0, 2), 32'h83);
    wr(ch_a(0, 0), 32'd10);
    idle(40);
    rd(ch_a(0, 1), 32'h0, "R8 reaches zero");
    rd(A_RAW, 32'h1, "R8 raw set");
    rd(A_MSK, 32'h0, "R10 masked off");
    chk_irq(1'b0, "R10 irq masked");
    wr(A_MASK, 32'h1);
    rd(A_MSK, 32'h1, "R10 masked on");
    chk_irq(1'b1, "R10 irq high");
    wr(A_CLR, 32'h1);
    idle(40);
    rd(A_RAW, 32'h0, "R8 no re-fire after clear");
    rd(ch_a(0, 1), 32'h0, "R8 parks at zero");
    chk_irq(1'b0, "R10 irq low after clear");
    wr(A_MASK, 32'h0);

    // R4 divide by 16, one-shot channel 3
    wr(ch_a(3, 2), 32'h87);
    wr(ch_a(3, 0), 32'd2);
    idle(5);
    rd(ch_a(3, 1), 32'd2, "R4 div16 before first step");
    idle(15);
    rd(ch_a(3, 1), 32'd1, "R4 div16 after one step");
    idle(12);
    rd(ch_a(3, 1), 32'd0, "R4 div16 after two steps");
    rd(A_RAW, 32'h8, "R8 ch3 raw");
    wr(ch_a(3, 2), 32'h0);
    wr(A_CLR, 32'hF);

    // R7 periodic with background reload, divide by 256
    wr(ch_a(1, 2), 32'hCA);
    wr(ch_a(1, 0), 32'd1);
    rd(ch_a(1, 1), 32'd1, "R3 R4 div256 count");
    wr(ch_a(1, 3), 32'd7);
    rd(ch_a(1, 1), 32'd1, "R7 bg write leaves count");
    idle(300);
    rd(ch_a(1, 1), 32'd0, "R4 div256 one step");
    rd(A_RAW, 32'h0, "R7 no raw before underflow");
    idle(300);
    rd(ch_a(1, 1), 32'd7, "R7 reload from background");
    rd(A_RAW, 32'h2, "R7 raw on underflow");
    wr(ch_a(1, 2), 32'h0);

    // R6 free-running 16-bit wrap
    wr(ch_a(2, 2), 32'h88);
    wr(ch_a(2, 0), 32'd0);
    idle(100);
    rd(ch_a(2, 1), 32'd0, "R6 before wrap");
    idle(200);
    rd(ch_a(2, 1), 32'h0000_FFFF, "R6 R5 wrap to 16-bit ones");
    rd(A_RAW, 32'h6, "R6 raw on wrap");
    wr(ch_a(2, 2), 32'h0);

    // R11 partial clear
    wr(A_CLR, 32'h2);
    rd(A_RAW, 32'h4, "R11 partial clear");

    // R10 mask selects
    wr(A_MASK, 32'h4);
    rd(A_MSK, 32'h4, "R10 masked bit2");
    chk_irq(1'b1, "R10 irq bit2");
    wr(A_MASK, 32'h2);
    rd(A_MSK, 32'h0, "R10 masked none");
    chk_irq(1'b0, "R10 irq none");

    // R6 32-bit free-running wrap, divide by 1
    wr(A_CLR, 32'hF);
    wr(ch_a(2, 2), 32'h82);
    wr(ch_a(2, 0), 32'd0);
    rd_m(ch_a(2, 1), 32'hFF00_0000, 32'hFF00_0000, "R6 32-bit wrap");
    rd(A_RAW, 32'h4, "R6 32-bit raw");

    idle(2);
    finish_run();
  end
endmodule